// File: doc/BRIEF.md
# Card Presence Detector with Interrupt

This block watches two mechanical card-detect switches, one for card slot A and one for card slot B. Each switch line first passes through a synchroniser. A digital debounce filter then accepts a new level only after that level has stayed unchanged for a programmable number of clock ticks. For 50 ms to 150 ms of debounce, set the tick count from the clock rate. Each slot can be set to a normally-open or a normally-closed switch. The chosen polarity turns the filtered level into a card-present status bit.

When a debounced change is accepted, the block records an interrupt for that slot and pulls the shared active-low interrupt line down. This happens for an insertion and for a removal. A removal also gives a one-cycle extraction pulse for that slot, which the power sequencer uses to start deactivation. The host clears the interrupt in one of two ways. It can raise chip select, which clears both slots. It can hold power-on high while chip select is low, which clears only the slot chosen by the slot-select line. The host programs the polarity with a small address-and-strobe write, and the new value takes effect on the rising edge of the program strobe.

Top module: `card_detect_irq`

## Requirements
- R1: After reset, both present outputs are 0, irq_n is 1, both extract outputs are 0, and both slots use normally-open polarity.
- R2: A change on a detect input is accepted only when the synchronised level stays unchanged for FILT_TICKS consecutive clock ticks. A shorter pulse changes no output.
- R3: With normally-open polarity, a slot reads present while its debounced input is low. With normally-closed polarity, it reads present while the input is high.
- R4: The present output of each slot follows that slot's accepted level and is independent of the other slot.
- R5: Every accepted change on either slot, whether insertion or removal, drives irq_n low in the same cycle that the status changes.
- R6: An accepted change that makes a slot absent gives exactly one cycle of high on that slot's extract output. An insertion gives no extract pulse.
- R7: A rising edge on cs_n clears the interrupt for both slots.
- R8: While cs_n is low and pwr_on is high, the interrupt of the selected slot is cleared (card_sel 1 selects A, 0 selects B). The interrupt of the other slot stays pending and keeps irq_n low.
- R9: A polarity write is staged while cs_n and pgm_n are both low and addr equals 4'b1100 (normally open) or 4'b1101 (normally closed), with card_sel 1 for slot A and 0 for slot B. It takes effect on the next rising edge of pgm_n.
- R10: A strobe with any other address, or with cs_n high, leaves both polarities unchanged. A polarity change alone never raises the interrupt.
- R11: If an accepted change and a clear condition fall in the same cycle, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_a_raw | input | 1 | Raw card-detect switch, slot A |
| det_b_raw | input | 1 | Raw card-detect switch, slot B |
| cs_n | input | 1 | Active-low chip select; rising edge clears interrupt |
| pgm_n | input | 1 | Active-low program strobe; rising edge applies polarity |
| addr | input | 4 | Function code for polarity writes |
| card_sel | input | 1 | Slot select: 1 = A, 0 = B |
| pwr_on | input | 1 | Power-on request; with cs_n low clears selected slot's interrupt |
| irq_n | output | 1 | Active-low interrupt |
| present_a | output | 1 | Slot A card present |
| present_b | output | 1 | Slot B card present |
| extract_a | output | 1 | One-cycle pulse on accepted removal, slot A |
| extract_b | output | 1 | One-cycle pulse on accepted removal, slot B |

## Verification
The hardest case to reach is R11. A filter acceptance has to fall in the exact cycle that a chip-select rising edge is sampled. Synchronisation and debounce together delay that acceptance by a fixed number of ticks after the raw change. The stimulus therefore holds cs_n low, changes the detect line, and counts that delay before raising cs_n, so that the set and the clear collide on one edge. A behavioural model compares irq_n on every cycle. It also covers the partial clear of R8, where one slot's interrupt is released while the other slot is still pending.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
   // polarity encoding: 0 = normally open switch, 1 = normally closed
   typedef enum logic {
      SW_OPEN   = 1'b0,
      SW_CLOSED = 1'b1
   } sw_pol_e;

   localparam int unsigned NUM_SLOTS = 2;
   // upper three bits of a polarity write code; bit 0 carries the polarity
   localparam logic [2:0]  POL_CODE_HI = 3'b110;
   // slot indices
   localparam int unsigned SLOT_A = 0;
   localparam int unsigned SLOT_B = 1;
endpackage

// File: rtl/cdet_filter.sv
module cdet_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TICKS  = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o,
   output logic accept_o
);
   localparam int unsigned CW = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp;
   logic                   cand_q;
   logic [CW-1:0]          cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign smp = sync_q[SYNC_STAGES-1];

   assign accept_o = (smp == cand_q) && (cand_q != level_o) && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q  <= 1'b1;
         level_o <= 1'b1;
         cnt_q   <= '0;
      end else if (smp != cand_q) begin
         cand_q <= smp;
         cnt_q  <= '0;
      end else if (cand_q != level_o) begin
         if (accept_o) level_o <= cand_q;
         else          cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cdet_polreg.sv
module cdet_polreg
   import cdet_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 pgm_n,
   input  logic [3:0]           addr,
   input  logic                 card_sel,
   output logic [NUM_SLOTS-1:0] pol_o
);
   logic pgm_q, armed_q, stg_sel_q;
   sw_pol_e stg_pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgm_q     <= 1'b1;
         armed_q   <= 1'b0;
         stg_sel_q <= 1'b0;
         stg_pol_q <= SW_OPEN;
         pol_o     <= {NUM_SLOTS{SW_OPEN}};
      end else begin
         pgm_q <= pgm_n;
         if (!cs_n && !pgm_n) begin
            armed_q   <= (addr[3:1] == POL_CODE_HI);
            stg_sel_q <= card_sel;
            stg_pol_q <= sw_pol_e'(addr[0]);
         end else if (!pgm_q && pgm_n && armed_q) begin
            armed_q <= 1'b0;
            if (stg_sel_q) pol_o[SLOT_A] <= stg_pol_q;
            else           pol_o[SLOT_B] <= stg_pol_q;
         end
      end
   end
endmodule

// File: rtl/cdet_irq.sv
module cdet_irq
   import cdet_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 pwr_on,
   input  logic                 card_sel,
   input  logic [NUM_SLOTS-1:0] accept_i,
   input  logic [NUM_SLOTS-1:0] removal_i,
   output logic [NUM_SLOTS-1:0] extract_o,
   output logic                 irq_n
);
   logic                 cs_q, cs_rise;
   logic [NUM_SLOTS-1:0] pend_q, sel_clr;

   assign cs_rise         = !cs_q && cs_n;
   assign sel_clr[SLOT_A] = pwr_on && !cs_n && card_sel;
   assign sel_clr[SLOT_B] = pwr_on && !cs_n && !card_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b1;
         pend_q    <= '0;
         extract_o <= '0;
      end else begin
         cs_q      <= cs_n;
         extract_o <= accept_i & removal_i;
         for (int k = 0; k < NUM_SLOTS; k++) begin
            if (accept_i[k])                 pend_q[k] <= 1'b1;
            else if (cs_rise || sel_clr[k])  pend_q[k] <= 1'b0;
         end
      end
   end

   assign irq_n = ~|pend_q;
endmodule

// File: rtl/card_detect_irq.sv
module card_detect_irq
   import cdet_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TICKS  = 2_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       det_a_raw,
   input  logic       det_b_raw,
   input  logic       cs_n,
   input  logic       pgm_n,
   input  logic [3:0] addr,
   input  logic       card_sel,
   input  logic       pwr_on,
   output logic       irq_n,
   output logic       present_a,
   output logic       present_b,
   output logic       extract_a,
   output logic       extract_b
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("card_detect_irq: SYNC_STAGES must be at least 2");
   end
   if (FILT_TICKS < 2) begin : g_bad_filt
      $error("card_detect_irq: FILT_TICKS must be at least 2");
   end

   logic [NUM_SLOTS-1:0] raw_v, lvl_v, acc_v, pol_v, pres_v, rem_v, ext_v;

   assign raw_v = {det_b_raw, det_a_raw};

   cdet_polreg u_pol (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pgm_n(pgm_n),
      .addr(addr), .card_sel(card_sel), .pol_o(pol_v)
   );

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      cdet_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TICKS(FILT_TICKS)) u_filt (
         .clk(clk), .rst_n(rst_n), .raw_i(raw_v[k]),
         .level_o(lvl_v[k]), .accept_o(acc_v[k])
      );
      // normally closed: high level means present; normally open: low
      assign pres_v[k] = (pol_v[k] == SW_CLOSED) ? lvl_v[k] : ~lvl_v[k];
      // the accepted level is the inverse of the current one, so the new
      // status is the inverse of the present one: removal when present now
      assign rem_v[k]  = pres_v[k];
   end

   cdet_irq u_irq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pwr_on(pwr_on),
      .card_sel(card_sel), .accept_i(acc_v), .removal_i(rem_v),
      .extract_o(ext_v), .irq_n(irq_n)
   );

   assign present_a = pres_v[SLOT_A];
   assign present_b = pres_v[SLOT_B];
   assign extract_a = ext_v[SLOT_A];
   assign extract_b = ext_v[SLOT_B];
endmodule

// File: rtl/cdet_chk.sv
module cdet_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       pgm_n,
   input logic       pwr_on,
   input logic       irq_n,
   input logic       extract_a,
   input logic       extract_b,
   input logic [1:0] pol
);
   // R6
   ext_a_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      extract_a |=> !extract_a);
   // R6
   ext_b_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      extract_b |=> !extract_b);
   // R5
   ext_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (extract_a || extract_b) |-> !irq_n);
   // R7 and R8
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> (($past(cs_n) && !$past(cs_n, 2)) ||
                        ($past(pwr_on) && !$past(cs_n))));
   // R9
   pol_a_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol[0]) |-> ($past(pgm_n) && !$past(pgm_n, 2)));
   // R9
   pol_b_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol[1]) |-> ($past(pgm_n) && !$past(pgm_n, 2)));
endmodule

bind card_detect_irq cdet_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pgm_n(pgm_n), .pwr_on(pwr_on),
   .irq_n(irq_n), .extract_a(extract_a), .extract_b(extract_b), .pol(pol_v)
);

// File: tb/card_detect_irq_tb.sv
module card_detect_irq_tb;
   localparam int SYNC = 2;
   localparam int FILT = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic det_a = 1'b1, det_b = 1'b1, cs_n = 1'b1, pgm_n = 1'b1, card_sel = 1'b0, pwr_on = 1'b0;
   logic [3:0] addr = 4'h0;
   logic irq_n, present_a, present_b, extract_a, extract_b;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   card_detect_irq #(.SYNC_STAGES(SYNC), .FILT_TICKS(FILT)) u_dut (
      .clk(clk), .rst_n(rst_n), .det_a_raw(det_a), .det_b_raw(det_b),
      .cs_n(cs_n), .pgm_n(pgm_n), .addr(addr), .card_sel(card_sel),
      .pwr_on(pwr_on), .irq_n(irq_n), .present_a(present_a),
      .present_b(present_b), .extract_a(extract_a), .extract_b(extract_b)
   );

   // behavioural reference model
   bit hq[2][$];
   int run[2];
   bit cand[2], lvl[2], pol[2], pend[2], ext[2];
   bit cs_prev, pgm_prev, armed, stg_sel, stg_pol;

   function automatic bit m_pres(int k);
      return pol[k] ? lvl[k] : !lvl[k];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            hq[k].delete();
            for (int i = 0; i < SYNC; i++) hq[k].push_back(1'b1);
            run[k] = FILT + 1; cand[k] = 1; lvl[k] = 1; pol[k] = 0; pend[k] = 0; ext[k] = 0;
         end
         cs_prev = 1; pgm_prev = 1; armed = 0; stg_sel = 0; stg_pol = 0;
      end else begin
         bit acc[2];
         bit rem[2];
         bit s;
         bit clr[2];
         for (int k = 0; k < 2; k++) begin
            s = hq[k].pop_front();
            hq[k].push_back(k == 0 ? det_a : det_b);
            if (s != cand[k]) begin cand[k] = s; run[k] = 1; end
            else run[k]++;
            acc[k] = (run[k] == FILT + 1) && (cand[k] != lvl[k]);
            rem[k] = m_pres(k);
         end
         clr[0] = pwr_on && !cs_n && card_sel;
         clr[1] = pwr_on && !cs_n && !card_sel;
         for (int k = 0; k < 2; k++) begin
            ext[k] = acc[k] && rem[k];
            if (acc[k]) begin pend[k] = 1; lvl[k] = cand[k]; end
            else if ((!cs_prev && cs_n) || clr[k]) pend[k] = 0;
         end
         if (!cs_n && !pgm_n) begin
            armed = (addr[3:1] == 3'b110); stg_sel = card_sel; stg_pol = addr[0];
         end else if (!pgm_prev && pgm_n && armed) begin
            armed = 0;
            if (stg_sel) pol[0] = stg_pol; else pol[1] = stg_pol;
         end
         cs_prev = cs_n; pgm_prev = pgm_n;
      end
   end

   task automatic chk(string tag, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare on every cycle, away from the active edge
   always @(negedge clk) if (rst_n && !done) begin
      chk("R4", "present_a", present_a, m_pres(0));
      chk("R4", "present_b", present_b, m_pres(1));
      chk("R5", "irq_n", irq_n, !(pend[0] || pend[1]));
      chk("R6", "extract_a", extract_a, ext[0]);
      chk("R6", "extract_b", extract_b, ext[1]);
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_pulse();
      cs_n = 0; cyc(2); cs_n = 1; cyc(2);
   endtask

   task automatic pol_write(logic [3:0] a, logic sel, logic csv);
      cs_n = csv; addr = a; card_sel = sel; pgm_n = 0; cyc(2);
      pgm_n = 1; cyc(2); cs_n = 1; cyc(2);
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1", "present_a", present_a, 1'b0);
      chk("R1", "present_b", present_b, 1'b0);
      chk("R1", "irq_n", irq_n, 1'b1);
      chk("R1", "extract_a", extract_a, 1'b0);

      // R3 insertion on slot A, normally open
      det_a = 0; cyc(SYNC + FILT + 4);
      chk("R3", "present_a after insertion", present_a, 1'b1);
      chk("R5", "irq_n after insertion", irq_n, 1'b0);
      chk("R4", "present_b unaffected", present_b, 1'b0);

      // R7 chip select edge clears
      cs_pulse();
      chk("R7", "irq_n after cs edge", irq_n, 1'b1);

      // R2 short glitch on slot B
      det_b = 0; cyc(FILT - 3); det_b = 1; cyc(SYNC + FILT + 4);
      chk("R2", "present_b after glitch", present_b, 1'b0);
      chk("R2", "irq_n after glitch", irq_n, 1'b1);

      // R6 removal on A
      det_a = 1; cyc(SYNC + FILT + 4);
      chk("R6", "present_a after removal", present_a, 1'b0);
      chk("R5", "irq_n after removal", irq_n, 1'b0);

      // R8 selective clear: B selected leaves A pending
      cs_n = 0; card_sel = 0; pwr_on = 1; cyc(3);
      chk("R8", "irq_n with other slot cleared", irq_n, 1'b0);
      card_sel = 1; cyc(2);
      chk("R8", "irq_n with slot A cleared", irq_n, 1'b1);
      pwr_on = 0; cyc(1); cs_n = 1; cyc(2);

      // R9 program slot B normally closed; idle-high input now reads present
      pol_write(4'b1101, 1'b0, 1'b0);
      chk("R9", "present_b after NC write", present_b, 1'b1);
      chk("R10", "irq_n after polarity change", irq_n, 1'b1);
      chk("R3", "present_a still open polarity", present_a, 1'b0);

      // R10 invalid code and chip select high are ignored
      pol_write(4'b1110, 1'b1, 1'b0);
      chk("R10", "present_a after bad code", present_a, 1'b0);
      pol_write(4'b1101, 1'b1, 1'b1);
      chk("R10", "present_a after cs high write", present_a, 1'b0);

      // R6 removal on B under normally closed
      det_b = 0; cyc(SYNC + FILT + 4);
      chk("R6", "present_b after NC removal", present_b, 1'b0);
      chk("R5", "irq_n after NC removal", irq_n, 1'b0);
      cs_pulse();
      chk("R7", "irq_n cleared again", irq_n, 1'b1);

      // R11 acceptance on the same edge as the cs rising edge
      cs_n = 0; cyc(2);
      det_a = 0; cyc(SYNC + FILT);
      cs_n = 1; cyc(3);
      chk("R11", "irq_n when set meets clear", irq_n, 1'b0);
      chk("R11", "present_a after collided insertion", present_a, 1'b1);
      cs_pulse();
      chk("R7", "irq_n final clear", irq_n, 1'b1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule